// File: doc/BRIEF.md
# Graded Reset Sequencer

The block collects reset requests from five sources and turns each into a reset sequence. Each sequence has one of three levels. The sources are a power-on request, a bidirectional open-drain hard-reset pin, a watchdog expiry event, a bus-monitor expiry event and a request from the test access port, which is raised during boundary-scan style commands. Each source maps to a level. Power-on is the heaviest level: it resets the clock generator and it is the only level that strobes the sampling of the configuration inputs. The hard level pulls the shared pin low and resets the core. The soft level resets only the core.

All request inputs pass through a two-stage synchronizer on the reference clock. A sequence holds its reset for a fixed number of cycles. After a hard or power-on hold, the block waits until the pin is seen high, and then waits a settle time before it releases the core. When requests overlap, the most severe level wins. A five-bit cause register records every source that took part in the most recent reset. It is cleared by writing ones to its bits.

Top module: `rstctl_top`

## Requirements
- R1: While the synchronized power-on request is high, `core_rst`, `clkgen_rst` and `hrst_pin_oe` are all high. After a power-on reset, the cause register reads exactly 5'b00001.
- R2: `cfg_strobe` pulses for exactly one cycle per power-on sequence, and only while `core_rst` is high. It never pulses for a hard or soft sequence.
- R3: A hard sequence raises `hrst_pin_oe` for exactly HOLD_CYC (default 16) consecutive cycles and leaves `clkgen_rst` low. A hard sequence is started by a low pin level, a watchdog event or a bus-monitor event.
- R4: After the pin enable drops, `core_rst` stays high for as long as the pin level is low. It is released no sooner than SETTLE_CYC (default 16) cycles after the pin returns high.
- R5: A test-port request gives a soft sequence. `core_rst` is high for exactly HOLD_CYC+SETTLE_CYC cycles, and `hrst_pin_oe`, `clkgen_rst` and `cfg_strobe` stay low.
- R6: Two rules pick the level when requests overlap. If hard and soft requests arrive together, the sequence is hard. A hard request that arrives during a soft hold upgrades the sequence to hard.
- R7: The cause register bits are: bit0 power-on, bit1 external pin, bit2 watchdog, bit3 bus monitor, bit4 test port. A sequence started from idle discards earlier bits. Every source seen during that sequence is added.
- R8: A cycle with `stat_clr_we` high clears the bits set in `stat_clr_mask`. If a source sets a bit in the same cycle that the bit is cleared, the bit ends up set.
- R9: `hrst_pin_oe` is never high without `core_rst`, and `clkgen_rst` is never high without `hrst_pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_req | input | 1 | Power-on reset request, active high, asynchronous |
| hrst_pin_in | input | 1 | Level read back from the hard-reset pin, low = asserted |
| wdog_expire | input | 1 | Watchdog expiry event, active high |
| busmon_expire | input | 1 | Bus-monitor expiry event, active high |
| tap_req | input | 1 | Test-port reset request, active high |
| stat_clr_we | input | 1 | Write strobe for clearing cause bits |
| stat_clr_mask | input | 5 | Ones select the cause bits to clear |
| core_rst | output | 1 | Core reset, active high |
| clkgen_rst | output | 1 | Clock-generator reset, active high |
| cfg_strobe | output | 1 | One-cycle configuration sample pulse |
| hrst_pin_oe | output | 1 | Pull the hard-reset pin low when high; the pin is never driven high |
| stat_q | output | 5 | Cause register |

## Verification
Two functions can fall in the same cycle: a source setting a cause bit and a software clear of that same bit. The bench provokes the overlap by holding the test-port request high through a sequence and writing a clear of bit 4 in the middle of it. It judges the result by reading bit 4 back as set in the next cycle. The bench also raises a hard and a soft request in one cycle, and raises a hard request during a soft hold. In both cases it judges the outcome by the pin enable width and the cause bits.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int SRC_N    = 5;
    localparam int SRC_POR  = 0;
    localparam int SRC_PIN  = 1;
    localparam int SRC_WDOG = 2;
    localparam int SRC_BUS  = 3;
    localparam int SRC_TAP  = 4;

    typedef logic [SRC_N-1:0] src_t;

    // Severity order matters: larger value wins.
    typedef enum logic [1:0] {
        LV_NONE = 2'd0,
        LV_SOFT = 2'd1,
        LV_HARD = 2'd2,
        LV_POR  = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_WAITPIN = 2'd2,
        ST_SETTLE  = 2'd3
    } st_e;

    typedef struct packed {
        logic tap;
        logic bus;
        logic wdog;
        logic pin_low;
        logic por;
    } req_t;

    function automatic lvl_e lvl_max(lvl_e a, lvl_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) stg[0] <= d;

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) stg[i] <= stg[i-1];
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rstctl_seq.sv
module rstctl_seq
    import rstctl_pkg::*;
#(
    parameter int HOLD_CYC   = 16,
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  req_t req_s,
    output logic start_o,
    output src_t seen_o,
    output logic core_rst,
    output logic clkgen_rst,
    output logic pin_oe,
    output logic cfg_strobe
);
    localparam int CNT_MAX = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

    st_e              state;
    lvl_e             lvl;
    logic [CNT_W-1:0] cnt;
    logic             strobe_q;

    logic pin_watch, pin_req, quiet, restart;
    lvl_e req_lvl, new_lvl;

    always_comb begin
        // The pin is only a request when this block is not pulling it low.
        pin_watch = (state == ST_IDLE) || (state == ST_SETTLE) || (lvl == LV_SOFT);
        pin_req   = req_s.pin_low && pin_watch;
        if (pin_req || req_s.wdog || req_s.bus) req_lvl = LV_HARD;
        else if (req_s.tap)                      req_lvl = LV_SOFT;
        else                                     req_lvl = LV_NONE;
        quiet   = (state == ST_IDLE) || (state == ST_SETTLE);
        restart = (req_lvl != LV_NONE) && (quiet || (req_lvl > lvl));
        new_lvl = quiet ? req_lvl : lvl_max(lvl, req_lvl);
        start_o = restart && (state == ST_IDLE) && !req_s.por;
        seen_o  = '0;
        if (!req_s.por) begin
            seen_o[SRC_PIN]  = pin_req;
            seen_o[SRC_WDOG] = req_s.wdog;
            seen_o[SRC_BUS]  = req_s.bus;
            seen_o[SRC_TAP]  = req_s.tap;
        end
    end

    always_ff @(posedge clk) begin
        if (req_s.por) begin
            state    <= ST_HOLD;
            lvl      <= LV_POR;
            cnt      <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (restart) begin
                state <= ST_HOLD;
                lvl   <= new_lvl;
                cnt   <= '0;
            end else begin
                case (state)
                    ST_HOLD: begin
                        if (cnt == HOLD_LAST) begin
                            cnt      <= '0;
                            state    <= (lvl == LV_SOFT) ? ST_SETTLE : ST_WAITPIN;
                            strobe_q <= (lvl == LV_POR);
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WAITPIN: begin
                        if (!req_s.pin_low) begin
                            state <= ST_SETTLE;
                            cnt   <= '0;
                        end
                    end
                    ST_SETTLE: begin
                        if (cnt == SETTLE_LAST) begin
                            state <= ST_IDLE;
                            lvl   <= LV_NONE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign core_rst   = req_s.por || (state != ST_IDLE);
    assign clkgen_rst = req_s.por || ((state == ST_HOLD) && (lvl == LV_POR));
    assign pin_oe     = req_s.por || ((state == ST_HOLD) && (lvl >= LV_HARD));
    assign cfg_strobe = strobe_q;
endmodule

// File: rtl/rstctl_status.sv
module rstctl_status
    import rstctl_pkg::*;
(
    input  logic clk,
    input  logic por_s,
    input  logic start,
    input  src_t seen,
    input  logic clr_we,
    input  src_t clr_mask,
    output src_t q
);
    src_t kept;

    always_comb begin
        kept = start ? '0 : q;
        if (clr_we) kept = kept & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (por_s) q <= src_t'(1 << SRC_POR);
        else       q <= kept | seen;
    end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int HOLD_CYC    = 16,
    parameter int SETTLE_CYC  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_req,
    input  logic             hrst_pin_in,
    input  logic             wdog_expire,
    input  logic             busmon_expire,
    input  logic             tap_req,
    input  logic             stat_clr_we,
    input  logic [SRC_N-1:0] stat_clr_mask,
    output logic             core_rst,
    output logic             clkgen_rst,
    output logic             cfg_strobe,
    output logic             hrst_pin_oe,
    output logic [SRC_N-1:0] stat_q
);
    req_t req_raw, req_s;
    logic start;
    src_t seen;
    logic por_s;

    assign req_raw = '{tap: tap_req, bus: busmon_expire, wdog: wdog_expire,
                       pin_low: ~hrst_pin_in, por: por_req};

    rstctl_sync #(.W($bits(req_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (req_raw),
        .q   (req_s)
    );

    assign por_s = req_s.por;

    rstctl_seq #(.HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk        (clk),
        .req_s      (req_s),
        .start_o    (start),
        .seen_o     (seen),
        .core_rst   (core_rst),
        .clkgen_rst (clkgen_rst),
        .pin_oe     (hrst_pin_oe),
        .cfg_strobe (cfg_strobe)
    );

    rstctl_status u_status (
        .clk      (clk),
        .por_s    (por_s),
        .start    (start),
        .seen     (seen),
        .clr_we   (stat_clr_we),
        .clr_mask (stat_clr_mask),
        .q        (stat_q)
    );
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
    parameter int HOLD_CYC = 16
) (
    input logic       clk,
    input logic       por_s,
    input logic       core_rst,
    input logic       clkgen_rst,
    input logic       pin_oe,
    input logic       cfg_strobe,
    input logic       stat_clr_we,
    input logic [4:0] stat_q
);
    logic [31:0] oe_run;

    always_ff @(posedge clk) begin
        if (por_s)       oe_run <= '0;
        else if (pin_oe) oe_run <= oe_run + 1;
        else             oe_run <= '0;
    end

    assert_por_cause_R1: assert property (@(posedge clk)
        por_s |=> (stat_q == 5'b00001));

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (por_s)
        cfg_strobe |=> !cfg_strobe);

    assert_strobe_in_reset_R2: assert property (@(posedge clk) disable iff (por_s)
        cfg_strobe |-> (core_rst && !clkgen_rst));

    assert_hold_width_R3: assert property (@(posedge clk) disable iff (por_s)
        oe_run <= HOLD_CYC);

    assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (por_s)
        (core_rst && !stat_clr_we) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    assert_pin_needs_core_R9: assert property (@(posedge clk) disable iff (por_s)
        pin_oe |-> core_rst);

    assert_clkgen_needs_pin_R9: assert property (@(posedge clk)
        clkgen_rst |-> pin_oe);
endmodule

bind rstctl_top rstctl_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk         (clk),
    .por_s       (por_s),
    .core_rst    (core_rst),
    .clkgen_rst  (clkgen_rst),
    .pin_oe      (hrst_pin_oe),
    .cfg_strobe  (cfg_strobe),
    .stat_clr_we (stat_clr_we),
    .stat_q      (stat_q)
);

// File: tb/rstctl_top_bench.sv
`timescale 1ns/1ps
module rstctl_top_bench;
    localparam int HOLD   = 16;
    localparam int SETTLE = 16;

    logic       clk = 1'b0;
    logic       por_req = 1'b1;
    logic       ext_drive = 1'b0;
    logic       wdog_expire = 1'b0;
    logic       busmon_expire = 1'b0;
    logic       tap_req = 1'b0;
    logic       stat_clr_we = 1'b0;
    logic [4:0] stat_clr_mask = '0;
    logic       core_rst, clkgen_rst, cfg_strobe, hrst_pin_oe;
    logic [4:0] stat_q;
    logic       hrst_pin;

    int n_chk = 0;
    int n_err = 0;

    // Open-drain wired pin: low when either side pulls it.
    assign hrst_pin = !(hrst_pin_oe || ext_drive);

    always #2 clk = ~clk;

    rstctl_top #(.HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE)) u_rstctl_top (
        .clk           (clk),
        .por_req       (por_req),
        .hrst_pin_in   (hrst_pin),
        .wdog_expire   (wdog_expire),
        .busmon_expire (busmon_expire),
        .tap_req       (tap_req),
        .stat_clr_we   (stat_clr_we),
        .stat_clr_mask (stat_clr_mask),
        .core_rst      (core_rst),
        .clkgen_rst    (clkgen_rst),
        .cfg_strobe    (cfg_strobe),
        .hrst_pin_oe   (hrst_pin_oe),
        .stat_q        (stat_q)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic observe(output int n_oe, output int n_clk, output int n_stb,
                           output int n_core, output int n_bad);
        bit was_core = 0;
        n_oe = 0; n_clk = 0; n_stb = 0; n_core = 0; n_bad = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (hrst_pin_oe) n_oe++;
            if (clkgen_rst)  n_clk++;
            if (cfg_strobe)  n_stb++;
            if ((hrst_pin_oe && !core_rst) || (clkgen_rst && !hrst_pin_oe)) n_bad++;
            if (core_rst) begin
                n_core++;
                was_core = 1;
            end else if (was_core) begin
                break;
            end
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && core_rst; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_por();
        int a, b, c, d, e;
        repeat (5) @(negedge clk);
        chk("R1 outputs during power-on", {29'd0, core_rst, clkgen_rst, hrst_pin_oe}, 7);
        por_req = 1'b0;
        observe(a, b, c, d, e);
        chk("R2 strobe count on power-on", c, 1);
        chk("R1 cause after power-on", stat_q, 5'b00001);
        wait_idle();
    endtask

    task automatic t_soft();
        int a, b, c, d, e;
        @(negedge clk) tap_req = 1'b1;
        @(negedge clk) tap_req = 1'b0;
        observe(a, b, c, d, e);
        chk("R5 soft pin enable cycles", a, 0);
        chk("R5 soft clkgen cycles", b, 0);
        chk("R2 soft strobe count", c, 0);
        chk("R5 soft core reset cycles", d, HOLD + SETTLE);
        chk("R7 cause after soft", stat_q, 5'b10000);
        wait_idle();
    endtask

    task automatic t_pin();
        int a, b, c, d, e;
        @(negedge clk) ext_drive = 1'b1;
        @(negedge clk) ext_drive = 1'b0;
        observe(a, b, c, d, e);
        chk("R3 pin-start enable cycles", a, HOLD);
        chk("R3 pin-start clkgen cycles", b, 0);
        chk("R2 pin-start strobe count", c, 0);
        chk("R7 cause after pin", stat_q, 5'b00010);
        wait_idle();
    endtask

    task automatic t_wdog();
        int a, b, c, d, e;
        @(negedge clk) wdog_expire = 1'b1;
        @(negedge clk) wdog_expire = 1'b0;
        observe(a, b, c, d, e);
        chk("R3 watchdog enable cycles", a, HOLD);
        chk_rng("R4 watchdog core reset cycles", d, HOLD + SETTLE + 2, HOLD + SETTLE + 4);
        chk("R9 output ordering violations", e, 0);
        chk("R7 cause after watchdog", stat_q, 5'b00100);
        wait_idle();
    endtask

    task automatic t_bus();
        int a, b, c, d, e;
        @(negedge clk) busmon_expire = 1'b1;
        @(negedge clk) busmon_expire = 1'b0;
        observe(a, b, c, d, e);
        chk("R3 bus-monitor enable cycles", a, HOLD);
        chk("R7 cause after bus monitor keeps latest only", stat_q, 5'b01000);
        wait_idle();
    endtask

    task automatic t_extend();
        int n = 0;
        @(negedge clk) wdog_expire = 1'b1;
        @(negedge clk) wdog_expire = 1'b0;
        for (int i = 0; i < 20 && !hrst_pin_oe; i++) @(negedge clk);
        ext_drive = 1'b1;
        repeat (60) @(negedge clk);
        chk("R4 core held while pin low", core_rst, 1);
        ext_drive = 1'b0;
        for (int i = 0; i < 100 && core_rst; i++) begin
            @(negedge clk);
            n++;
        end
        chk_rng("R4 settle after pin high", n, SETTLE, SETTLE + 4);
        chk("R7 cause with held pin", stat_q, 5'b00100);
        wait_idle();
    endtask

    task automatic t_prio();
        int a, b, c, d, e;
        @(negedge clk) begin tap_req = 1'b1; wdog_expire = 1'b1; end
        @(negedge clk) begin tap_req = 1'b0; wdog_expire = 1'b0; end
        observe(a, b, c, d, e);
        chk("R6 simultaneous hard+soft enable cycles", a, HOLD);
        chk("R7 cause simultaneous", stat_q, 5'b10100);
        wait_idle();
    endtask

    task automatic t_escalate();
        int a, b, c, d, e;
        @(negedge clk) tap_req = 1'b1;
        @(negedge clk) tap_req = 1'b0;
        repeat (6) @(negedge clk);
        wdog_expire = 1'b1;
        @(negedge clk) wdog_expire = 1'b0;
        observe(a, b, c, d, e);
        chk("R6 upgraded enable cycles", a, HOLD);
        chk("R6 upgraded clkgen cycles", b, 0);
        chk("R7 cause upgraded", stat_q, 5'b10100);
        wait_idle();
    endtask

    task automatic t_clear();
        @(negedge clk) begin stat_clr_we = 1'b1; stat_clr_mask = 5'b00100; end
        @(negedge clk) begin stat_clr_we = 1'b0; stat_clr_mask = '0; end
        chk("R8 clear watchdog bit", stat_q, 5'b10000);
        @(negedge clk) begin stat_clr_we = 1'b1; stat_clr_mask = 5'b11111; end
        @(negedge clk) begin stat_clr_we = 1'b0; stat_clr_mask = '0; end
        chk("R8 clear all", stat_q, 5'b00000);
        chk("R8 clear did not start reset", core_rst, 0);
    endtask

    task automatic t_same_cycle();
        tap_req = 1'b1;
        for (int i = 0; i < 20 && !core_rst; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        stat_clr_we = 1'b1; stat_clr_mask = 5'b10000;
        @(negedge clk) begin stat_clr_we = 1'b0; stat_clr_mask = '0; end
        chk("R8 set wins over clear", stat_q, 5'b10000);
        tap_req = 1'b0;
        wait_idle();
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_por();
        t_soft();
        t_pin();
        t_wdog();
        t_bus();
        t_extend();
        t_prio();
        t_escalate();
        t_clear();
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule